// File: doc/BRIEF.md
# Programmable 14-bit Down-Count Timer

This block is a 14-bit down counter that advances on rising edges of an external timer input, not on the system clock. The host writes two bytes. The low byte holds length bits 7:0. The high byte holds length bits 13:8 in its bits 5:0 and a 2-bit waveform mode in its bits 7:6. A 2-bit control code then starts the timer, stops it at once, or stops it after the current count. The bus decoder around the block supplies three things: separate write strobes for the two length bytes (register offsets 4 and 5), a strobe for the control code, and a pulse for each status read.

The timer output idles high. It carries one of four waveforms: a single square wave, a repeating square wave, a single low pulse, or a repeating low pulse. When the counter finishes a count it raises a terminal-count flag. The flag appears as bit 0 of a 2-bit status slice, which the decoder maps to status bits 7:6. Reading status clears the flag.

A count of L means L qualified input edges from the start (or from a reload) to terminal count. Terminal count is the edge that arrives while the counter holds 1.

Top module: `tmr14_down`

## Requirements
- R1: After reset, `tmr_run` is 0, `tmr_out` is 1 and `stat_tmr` is 2'b00.
- R2: The effective length is {high byte bits 5:0, low byte}. The mode is high byte bits 7:6. A length of 0 or 1 is treated as 2.
- R3: Control code 2'b11 while stopped does three things: it loads the effective length and mode, it sets `tmr_run`, and from then on each qualified input edge lowers the count by one.
- R4: Control code 2'b01 clears `tmr_run` on the next clock edge, even if an input edge arrives in the same cycle. It also cancels any pending reload or deferred stop. `tmr_out` is high one cycle after `tmr_run` falls.
- R5: Control code 2'b10 while running lets the count finish, then stops the timer at terminal count. It has no effect while stopped. A later code 2'b11 cancels it.
- R6: Control code 2'b00 changes nothing.
- R7: Control code 2'b11 while running leaves the current count alone. At the next terminal count the timer reloads from the length and mode registers, as they stand at that moment, and keeps running.
- R8: Mode 2'b00 gives one square wave. The output is high while the count is above floor(L/2), which lasts ceil(L/2) edges. It is low for the remaining floor(L/2) edges. At terminal count the timer stops and the output returns high.
- R9: Mode 2'b01 repeats the square wave of R8. At each terminal count it reloads from the length latched at start.
- R10: Mode 2'b10 drives the output low while the count is 1, then stops at terminal count.
- R11: Mode 2'b11 gives the low pulse of R10 at every terminal count and reloads the latched length each time.
- R12: Terminal count sets `stat_tmr[0]`. A status read clears it. If a terminal count and a read fall in the same cycle, the flag stays set. `stat_tmr[1]` always reads 0.
- R13: `tmr_in` passes through a two-stage synchronizer. Each rising edge counts exactly once, however long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_in | input | 1 | External count input, asynchronous to clk |
| len_lo_we | input | 1 | Write strobe for the low length byte |
| len_hi_we | input | 1 | Write strobe for the high length byte and mode bits |
| wr_data | input | 8 | Write data for both length bytes |
| ctl_we | input | 1 | Strobe for the control code |
| ctl_code | input | 2 | Control code: 00 none, 01 halt, 10 stop at terminal count, 11 start |
| stat_rd | input | 1 | One-cycle pulse marking a status read |
| tmr_out | output | 1 | Timer waveform output, idle high |
| tmr_run | output | 1 | High while the counter is running |
| stat_tmr | output | 2 | Status bits 7:6: bit 1 reads 0, bit 0 is the terminal-count flag |

## Verification
The assertions assume each strobe lasts one clock and carries a single valid operation. They also assume `tmr_in` stays at a level long enough for the synchronizer to catch every change, so that a qualified edge never merges with its neighbour. The stimulus holds the input high for two clocks and low for four, and spaces host operations so that they do not overlap. The one exception is a directed case that lines up a status read with a terminal count on purpose.

// File: rtl/tmr14_pkg.sv
package tmr14_pkg;

  typedef enum logic [1:0] {
    CTL_NOP   = 2'b00,
    CTL_HALT  = 2'b01,
    CTL_DRAIN = 2'b10,
    CTL_GO    = 2'b11
  } tmr_ctl_e;

  typedef enum logic [1:0] {
    WV_SQ_ONCE = 2'b00,
    WV_SQ_LOOP = 2'b01,
    WV_PL_ONCE = 2'b10,
    WV_PL_LOOP = 2'b11
  } tmr_wave_e;

  function automatic logic wave_reloads(tmr_wave_e m);
    return (m == WV_SQ_LOOP) || (m == WV_PL_LOOP);
  endfunction

  function automatic logic wave_is_pulse(tmr_wave_e m);
    return (m == WV_PL_ONCE) || (m == WV_PL_LOOP);
  endfunction

endpackage

// File: rtl/tmr_in_sync.sv
module tmr_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr_len_regs.sv
module tmr_len_regs
  import tmr14_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [7:0]    wdata,
  output logic [CW-1:0] len_eff,
  output tmr_wave_e     mode_cfg
);
  localparam int HI_W = CW - 8;
  localparam logic [CW-1:0] MIN_LEN = CW'(2);

  logic [7:0]      lo_q;
  logic [HI_W-1:0] hi_q;
  tmr_wave_e       mode_q;
  logic [CW-1:0]   len_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= WV_SQ_ONCE;
    end else begin
      if (lo_we) lo_q <= wdata;
      if (hi_we) begin
        hi_q   <= wdata[HI_W-1:0];
        mode_q <= tmr_wave_e'(wdata[7:6]);
      end
    end
  end

  assign len_raw  = {hi_q, lo_q};
  assign len_eff  = (len_raw < MIN_LEN) ? MIN_LEN : len_raw;
  assign mode_cfg = mode_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr14_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ctl_we,
  input  logic [1:0]    ctl_code,
  input  logic [CW-1:0] len_eff,
  input  tmr_wave_e     mode_cfg,
  output logic          run_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] ld_q,
  output tmr_wave_e     mode_q,
  output logic          tc_evt
);
  localparam logic [CW-1:0] LAST = CW'(1);

  tmr_ctl_e      ctl;
  logic          go, halt, drain;
  logic          pend_q, stop_q;
  logic          run_d, pend_d, stop_d, tc_d;
  logic [CW-1:0] cnt_d, ld_d;
  tmr_wave_e     mode_d;

  assign ctl   = tmr_ctl_e'(ctl_code);
  assign go    = ctl_we && (ctl == CTL_GO);
  assign halt  = ctl_we && (ctl == CTL_HALT);
  assign drain = ctl_we && (ctl == CTL_DRAIN);

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    ld_d   = ld_q;
    mode_d = mode_q;
    pend_d = pend_q;
    stop_d = stop_q;
    tc_d   = 1'b0;
    if (halt) begin
      run_d  = 1'b0;
      pend_d = 1'b0;
      stop_d = 1'b0;
    end else if (!run_q) begin
      if (go) begin
        run_d  = 1'b1;
        cnt_d  = len_eff;
        ld_d   = len_eff;
        mode_d = mode_cfg;
        pend_d = 1'b0;
        stop_d = 1'b0;
      end
    end else begin
      if (go) begin
        pend_d = 1'b1;
        stop_d = 1'b0;
      end else if (drain) begin
        stop_d = 1'b1;
      end
      if (tick) begin
        if (cnt_q == LAST) begin
          tc_d = 1'b1;
          if (stop_d) begin
            run_d  = 1'b0;
            stop_d = 1'b0;
            pend_d = 1'b0;
          end else if (pend_d) begin
            cnt_d  = len_eff;
            ld_d   = len_eff;
            mode_d = mode_cfg;
            pend_d = 1'b0;
          end else if (wave_reloads(mode_q)) begin
            cnt_d = ld_q;
          end else begin
            run_d = 1'b0;
          end
        end else begin
          cnt_d = cnt_q - LAST;
        end
      end
    end
  end

  assign tc_evt = tc_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      ld_q   <= '0;
      mode_q <= WV_SQ_ONCE;
      pend_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      ld_q   <= ld_d;
      mode_q <= mode_d;
      pend_q <= pend_d;
      stop_q <= stop_d;
    end
  end
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr14_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] ld,
  input  tmr_wave_e     mode,
  output logic          out_q
);
  logic [CW-1:0] half;
  logic          out_d;

  assign half = ld >> 1;

  always_comb begin
    if (!run)                     out_d = 1'b1;
    else if (wave_is_pulse(mode)) out_d = (cnt != CW'(1));
    else                          out_d = (cnt > half);
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b1;
    else     out_q <= out_d;
  end
endmodule

// File: rtl/tmr14_down.sv
module tmr14_down
  import tmr14_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tmr_in,
  input  logic       len_lo_we,
  input  logic       len_hi_we,
  input  logic [7:0] wr_data,
  input  logic       ctl_we,
  input  logic [1:0] ctl_code,
  input  logic       stat_rd,
  output logic       tmr_out,
  output logic       tmr_run,
  output logic [1:0] stat_tmr
);
  logic             tick;
  logic [CNT_W-1:0] len_eff, cnt_q, ld_q;
  tmr_wave_e        mode_cfg, mode_q;
  logic             run_q, tc_evt, flag_q;

  tmr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(tmr_in), .rise(tick)
  );

  tmr_len_regs #(.CW(CNT_W)) u_len (
    .clk(clk), .rst(rst), .lo_we(len_lo_we), .hi_we(len_hi_we),
    .wdata(wr_data), .len_eff(len_eff), .mode_cfg(mode_cfg)
  );

  tmr_core #(.CW(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .ctl_we(ctl_we), .ctl_code(ctl_code),
    .len_eff(len_eff), .mode_cfg(mode_cfg), .run_q(run_q), .cnt_q(cnt_q),
    .ld_q(ld_q), .mode_q(mode_q), .tc_evt(tc_evt)
  );

  tmr_wave #(.CW(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .run(run_q), .cnt(cnt_q), .ld(ld_q),
    .mode(mode_q), .out_q(tmr_out)
  );

  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (tc_evt)  flag_q <= 1'b1;
    else if (stat_rd) flag_q <= 1'b0;
  end

  assign tmr_run  = run_q;
  assign stat_tmr = {1'b0, flag_q};
endmodule

// File: rtl/tmr14_down_chk.sv
module tmr14_down_chk #(
  parameter int CW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          ctl_we,
  input logic [1:0]    ctl_code,
  input logic          stat_rd,
  input logic          tmr_out,
  input logic          tmr_run,
  input logic          flag,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] ld_q,
  input logic          tc_evt
);
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    tmr_run |-> (cnt_q != '0) && (cnt_q <= ld_q));

  assert_halt_now_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_code == 2'b01) |=> !tmr_run);

  assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
    !tmr_run |=> tmr_out);

  assert_nop_inert_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_code == 2'b00 && !tick) |=> ($stable(cnt_q) && $stable(tmr_run)));

  assert_hold_no_edge_R13: assert property (@(posedge clk) disable iff (rst)
    (tmr_run && !tick && !ctl_we) |=> $stable(cnt_q));

  assert_flag_set_R12: assert property (@(posedge clk) disable iff (rst)
    tc_evt |=> flag);

  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !tc_evt) |=> !flag);

  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (flag && !stat_rd) |=> flag);
endmodule

bind tmr14_down tmr14_down_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .ctl_we(ctl_we), .ctl_code(ctl_code),
  .stat_rd(stat_rd), .tmr_out(tmr_out), .tmr_run(tmr_run), .flag(stat_tmr[0]),
  .cnt_q(cnt_q), .ld_q(ld_q), .tc_evt(tc_evt)
);

// File: tb/sim_tmr14_down.sv
module sim_tmr14_down;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tmr_in = 1'b0;
  logic       len_lo_we = 1'b0, len_hi_we = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ctl_we = 1'b0;
  logic [1:0] ctl_code = '0;
  logic       stat_rd = 1'b0;
  logic       tmr_out, tmr_run;
  logic [1:0] stat_tmr;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic        m_run = 0, m_pend = 0, m_stop = 0, m_flag = 0;
  logic [13:0] m_cnt = 0, m_ld = 0;
  logic [1:0]  m_mode = 0;
  logic [7:0]  m_lo = 0, m_hi = 0;

  always #5 clk = ~clk;

  tmr14_down u0 (
    .clk(clk), .rst(rst), .tmr_in(tmr_in), .len_lo_we(len_lo_we),
    .len_hi_we(len_hi_we), .wr_data(wr_data), .ctl_we(ctl_we),
    .ctl_code(ctl_code), .stat_rd(stat_rd), .tmr_out(tmr_out),
    .tmr_run(tmr_run), .stat_tmr(stat_tmr)
  );

  function automatic logic [13:0] eff_len();
    logic [13:0] raw = {m_hi[5:0], m_lo};
    return (raw < 14'd2) ? 14'd2 : raw;
  endfunction

  function automatic logic exp_out();
    if (!m_run) return 1'b1;
    if (m_mode[1]) return (m_cnt != 14'd1);
    return (m_cnt > (m_ld >> 1));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, tmr_run, m_run);
    chk(req, tmr_out, exp_out());
    chk("R12", stat_tmr, {1'b0, m_flag});
  endtask

  task automatic model_tick();
    if (m_run) begin
      if (m_cnt == 14'd1) begin
        m_flag = 1'b1;
        if (m_stop) begin m_run = 0; m_stop = 0; m_pend = 0; end
        else if (m_pend) begin
          m_cnt = eff_len(); m_ld = eff_len(); m_mode = m_hi[7:6]; m_pend = 0;
        end
        else if (m_mode[0]) m_cnt = m_ld;
        else m_run = 0;
      end else m_cnt = m_cnt - 14'd1;
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_lo(logic [7:0] v);
    wr_data = v; len_lo_we = 1; @(negedge clk); len_lo_we = 0;
    m_lo = v; settle();
  endtask

  task automatic wr_hi(logic [7:0] v);
    wr_data = v; len_hi_we = 1; @(negedge clk); len_hi_we = 0;
    m_hi = v; settle();
  endtask

  task automatic cmd(logic [1:0] c);
    ctl_code = c; ctl_we = 1; @(negedge clk); ctl_we = 0;
    case (c)
      2'b01: begin m_run = 0; m_pend = 0; m_stop = 0; end
      2'b10: if (m_run) m_stop = 1;
      2'b11: if (!m_run) begin
               m_run = 1; m_cnt = eff_len(); m_ld = eff_len();
               m_mode = m_hi[7:6]; m_pend = 0; m_stop = 0;
             end else begin m_pend = 1; m_stop = 0; end
      default: ;
    endcase
    settle();
  endtask

  task automatic tick(int hi_len = 2);
    tmr_in = 1; repeat (hi_len) @(negedge clk);
    tmr_in = 0; repeat (4) @(negedge clk);
    model_tick();
  endtask

  task automatic rd_status();
    chk("R12", stat_tmr, {1'b0, m_flag});
    stat_rd = 1; @(negedge clk); stat_rd = 0;
    m_flag = 0; settle();
  endtask

  // read pulse lands on the same edge as the counting edge
  task automatic tick_with_read();
    tmr_in = 1; repeat (2) @(negedge clk);
    stat_rd = 1; tmr_in = 0; @(negedge clk); stat_rd = 0;
    repeat (4) @(negedge clk);
    m_flag = 0;
    model_tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", tmr_run, 0); chk("R1", tmr_out, 1); chk("R1", stat_tmr, 0);

    // R8: single square, L=5 -> high 3 edges, low 2
    wr_lo(8'd5); wr_hi(8'h00); cmd(2'b11);
    check_all("R3");
    for (int i = 0; i < 5; i++) begin
      tick(); check_all("R8");
      if (i == 1) chk("R8", tmr_out, 1);
      if (i == 2) chk("R8", tmr_out, 0);
    end
    chk("R8", tmr_run, 0); chk("R12", stat_tmr, 2'b01);
    rd_status(); chk("R12", stat_tmr, 2'b00);

    // R2: length 0 treated as 2; R10 single pulse
    wr_lo(8'd0); wr_hi(8'h80); cmd(2'b11);
    tick(); check_all("R10"); chk("R10", tmr_out, 0);
    tick(); check_all("R2"); chk("R2", tmr_run, 0);
    rd_status();

    // R2: high bits used: L = 0x102
    wr_lo(8'h02); wr_hi(8'h41); cmd(2'b11);
    for (int i = 0; i < 258; i++) tick();
    check_all("R2"); chk("R2", tmr_run, 1); chk("R9", stat_tmr, 2'b01);
    rd_status();
    cmd(2'b01); check_all("R4");

    // R13: long-held input counts once
    wr_lo(8'd3); wr_hi(8'h00); cmd(2'b11);
    tick(12); check_all("R13");
    tick(); check_all("R13"); chk("R13", tmr_out, 0);
    cmd(2'b01);

    // R11: repeated pulse; R6 nop; R4 halt mid-count
    wr_lo(8'd3); wr_hi(8'hC0); cmd(2'b11);
    for (int i = 0; i < 7; i++) begin tick(); check_all("R11"); end
    cmd(2'b00); check_all("R6");
    tick(); check_all("R6");
    cmd(2'b01); check_all("R4"); chk("R4", tmr_out, 1);
    tick(); check_all("R4");
    rd_status();

    // R5: deferred stop in loop mode, no effect when stopped
    wr_lo(8'd4); wr_hi(8'h40); cmd(2'b11);
    tick(); cmd(2'b10); check_all("R5");
    for (int i = 0; i < 3; i++) begin tick(); check_all("R5"); end
    chk("R5", tmr_run, 0);
    cmd(2'b10); check_all("R5");
    rd_status();

    // R7: start while running reloads new length at terminal count
    wr_lo(8'd3); wr_hi(8'h00); cmd(2'b11);
    wr_lo(8'd6); wr_hi(8'h40); cmd(2'b11);
    for (int i = 0; i < 9; i++) begin tick(); check_all("R7"); end
    chk("R7", tmr_run, 1);
    cmd(2'b01);

    // R12: terminal count and read on the same edge
    wr_lo(8'd2); wr_hi(8'h00); cmd(2'b11);
    tick(); tick_with_read(); check_all("R12"); chk("R12", stat_tmr, 2'b01);
    rd_status();

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0: wr_lo(8'($urandom_range(0, 9)));
        1: wr_hi({2'($urandom_range(0, 3)), 6'd0});
        2: cmd(2'($urandom_range(0, 3)));
        3: rd_status();
        default: tick();
      endcase
      check_all("R3");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule